// File: doc/BRIEF.md
# Raster/Linear Tick Timer with Match Interrupt

This block is a free-running timer for a coprocessor. It keeps a horizontal count in clock units and a vertical count. Each tick strobe moves the horizontal count forward by two clocks. In raster mode the horizontal count wraps at the line length and steps the vertical count. The vertical count then wraps at a line total chosen by a region input. In linear mode the horizontal count is a plain binary counter whose overflow carries into a vertical counter that wraps freely.

Software gives the horizontal compare value in dots, and one dot is four clocks. A two-bit match selector picks one of four conditions: no match, a horizontal match, a vertical match at the start of a line, or both counts matching together. A tick that lands on the selected condition raises a one-cycle flag event. If the timer interrupt is enabled, the same tick also raises a one-cycle request that drives the interrupt controller's timer clear bit to zero. Host register decode and readback latching sit outside this block.

Top module: `hv_match_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, `h_count`, `v_count`, `flag_set` and `clr_zero` are all zero.
- R2: Each cycle with `tick` high adds 2 to `h_count`, and the change shows on the following cycle. With `tick` low, both counts hold.
- R3: In raster mode (`lin_mode`=0), a tick that brings the horizontal count to LINE_CLKS or more sets `h_count` to 0 and adds one to `v_count`.
- R4: In raster mode, a vertical step that reaches the line total sets `v_count` to 0. The line total is LINES_A when `region_sel`=0 and LINES_B when `region_sel`=1.
- R5: In linear mode (`lin_mode`=1), `h_count` is an H_W-bit counter. Its carry out adds one to the V_W-bit `v_count`, which wraps from its maximum to 0.
- R6: With `match_sel`=1, a tick whose new `h_count` equals `h_cmp`×4 raises `flag_set` for one cycle.
- R7: With `match_sel`=2, a tick whose new `v_count` equals `v_cmp` while the new `h_count` is 0 raises `flag_set`.
- R8: With `match_sel`=3, `flag_set` is raised only when the new `h_count` equals `h_cmp`×4 and the new `v_count` equals `v_cmp` at the same time.
- R9: With `match_sel`=0, `flag_set` never rises.
- R10: `clr_zero` pulses in the same cycle as `flag_set` when `irq_en`=1, and it stays low when `irq_en`=0.
- R11: A change of `lin_mode` leaves both counts as they are. The new counting rule takes effect from the next tick. If the vertical count is already at or above the line total, the next raster line step sends it to 0.
- R12: The match is tested only on the counts that a tick has just produced. One matching tick gives exactly one flag pulse, and idle cycles give none, even while the counts still sit on the match point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Advance strobe, one count step per high cycle |
| lin_mode | input | 1 | 0 raster counting, 1 linear counting |
| region_sel | input | 1 | Selects line total LINES_A (0) or LINES_B (1) |
| match_sel | input | 2 | Match condition: 0 off, 1 horizontal, 2 vertical at line start, 3 both |
| h_cmp | input | CMP_W | Horizontal compare value in dots |
| v_cmp | input | V_W | Vertical compare value |
| irq_en | input | 1 | Timer interrupt enable |
| h_count | output | H_W | Horizontal count in clocks |
| v_count | output | V_W | Vertical count |
| flag_set | output | 1 | One-cycle timer flag event |
| clr_zero | output | 1 | One-cycle request to force the timer clear bit to 0 |

## Verification
The bench builds the timer with H_W=7, V_W=4, CMP_W=5, LINE_CLKS=40, LINES_A=5 and LINES_B=7. A raster line then takes 20 ticks, a full frame takes 100 or 140 ticks, and a full linear wrap takes 1024 ticks. Each wrap of the horizontal and vertical counts in both modes, and both region totals, therefore fits within a few thousand cycles. The compare range at CMP_W=5 still covers dot values whose ×4 scaling reaches the top of the 7-bit horizontal counter.

// File: rtl/hvt_pkg.sv
package hvt_pkg;
  typedef enum logic [1:0] {
    MATCH_OFF = 2'd0,
    MATCH_H   = 2'd1,
    MATCH_V   = 2'd2,
    MATCH_HV  = 2'd3
  } match_sel_e;
endpackage

// File: rtl/hvt_counter.sv
module hvt_counter #(
  parameter int H_W       = 11,
  parameter int V_W       = 9,
  parameter int STEP      = 2,
  parameter int LINE_CLKS = 1364,
  parameter int LINES_A   = 262,
  parameter int LINES_B   = 312
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           lin_mode,
  input  logic           region_sel,
  output logic [H_W-1:0] h_q,
  output logic [V_W-1:0] v_q,
  output logic [H_W-1:0] h_d,
  output logic [V_W-1:0] v_d
);
  localparam logic [H_W:0] LINE_LIM = (H_W+1)'(LINE_CLKS);
  localparam logic [H_W:0] STEP_W   = (H_W+1)'(STEP);
  localparam logic [V_W:0] TOT_A    = (V_W+1)'(LINES_A);
  localparam logic [V_W:0] TOT_B    = (V_W+1)'(LINES_B);

  logic [H_W:0] h_sum;
  logic [V_W:0] v_inc;
  logic [V_W:0] v_total;
  logic [H_W-1:0] h_ras, h_lin;
  logic [V_W-1:0] v_ras, v_lin;

  assign h_sum   = {1'b0, h_q} + STEP_W;
  assign v_inc   = {1'b0, v_q} + {{V_W{1'b0}}, 1'b1};
  assign v_total = region_sel ? TOT_B : TOT_A;

  // raster rule: wrap at line length, vertical wraps at region total
  always_comb begin
    if (h_sum >= LINE_LIM) begin
      h_ras = '0;
      v_ras = (v_inc >= v_total) ? '0 : v_inc[V_W-1:0];
    end else begin
      h_ras = h_sum[H_W-1:0];
      v_ras = v_q;
    end
  end

  // linear rule: carry out of horizontal feeds vertical
  assign h_lin = h_sum[H_W-1:0];
  assign v_lin = v_q + {{(V_W-1){1'b0}}, h_sum[H_W]};

  always_comb begin
    if (!tick) begin
      h_d = h_q;
      v_d = v_q;
    end else if (lin_mode) begin
      h_d = h_lin;
      v_d = v_lin;
    end else begin
      h_d = h_ras;
      v_d = v_ras;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(tick)) |-> ($stable(h_q) && $stable(v_q))); // R2

  AST_RASTER_BOUND: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(tick) && !$past(lin_mode)) |-> ({1'b0, h_q} < LINE_LIM)); // R3

  AST_LIN_CARRY: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(tick) && $past(lin_mode) && (h_q < $past(h_q)))
    |-> (v_q == $past(v_q) + 1'b1)); // R5
endmodule

// File: rtl/hvt_match.sv
module hvt_match
  import hvt_pkg::*;
#(
  parameter int H_W       = 11,
  parameter int V_W       = 9,
  parameter int CMP_W     = 9,
  parameter int DOT_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  match_sel_e       sel,
  input  logic             irq_en,
  input  logic [H_W-1:0]   h_d,
  input  logic [V_W-1:0]   v_d,
  input  logic [CMP_W-1:0] h_cmp,
  input  logic [V_W-1:0]   v_cmp,
  output logic             flag_set,
  output logic             clr_zero
);
  localparam int TGT_W = CMP_W + DOT_SHIFT;
  localparam int CW    = (H_W > TGT_W) ? H_W : TGT_W;

  logic [CW-1:0] h_ext, h_tgt;
  logic h_eq, h_zero, v_eq, hit;

  assign h_ext  = CW'(h_d);
  assign h_tgt  = CW'({h_cmp, {DOT_SHIFT{1'b0}}});
  assign h_eq   = (h_ext == h_tgt);
  assign h_zero = (h_d == '0);
  assign v_eq   = (v_d == v_cmp);

  always_comb begin
    unique case (sel)
      MATCH_H:  hit = h_eq;
      MATCH_V:  hit = v_eq && h_zero;
      MATCH_HV: hit = v_eq && h_eq;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_set <= 1'b0;
      clr_zero <= 1'b0;
    end else begin
      flag_set <= tick && hit;
      clr_zero <= tick && hit && irq_en;
    end
  end

  AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    flag_set |-> ($past(!rst) && $past(tick))); // R12

  AST_CLR_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    clr_zero |-> (flag_set && $past(irq_en))); // R10

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(sel) == MATCH_OFF)) |-> !flag_set); // R9
endmodule

// File: rtl/hv_match_timer.sv
module hv_match_timer
  import hvt_pkg::*;
#(
  parameter int H_W       = 11,
  parameter int V_W       = 9,
  parameter int CMP_W     = 9,
  parameter int STEP      = 2,
  parameter int DOT_SHIFT = 2,
  parameter int LINE_CLKS = 1364,
  parameter int LINES_A   = 262,
  parameter int LINES_B   = 312
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             lin_mode,
  input  logic             region_sel,
  input  logic [1:0]       match_sel,
  input  logic [CMP_W-1:0] h_cmp,
  input  logic [V_W-1:0]   v_cmp,
  input  logic             irq_en,
  output logic [H_W-1:0]   h_count,
  output logic [V_W-1:0]   v_count,
  output logic             flag_set,
  output logic             clr_zero
);
  logic [H_W-1:0] h_d;
  logic [V_W-1:0] v_d;
  match_sel_e     sel;

  assign sel = match_sel_e'(match_sel);

  hvt_counter #(
    .H_W(H_W), .V_W(V_W), .STEP(STEP),
    .LINE_CLKS(LINE_CLKS), .LINES_A(LINES_A), .LINES_B(LINES_B)
  ) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .lin_mode(lin_mode),
    .region_sel(region_sel),
    .h_q(h_count), .v_q(v_count), .h_d(h_d), .v_d(v_d)
  );

  hvt_match #(
    .H_W(H_W), .V_W(V_W), .CMP_W(CMP_W), .DOT_SHIFT(DOT_SHIFT)
  ) u_match (
    .clk(clk), .rst(rst), .tick(tick), .sel(sel), .irq_en(irq_en),
    .h_d(h_d), .v_d(v_d), .h_cmp(h_cmp), .v_cmp(v_cmp),
    .flag_set(flag_set), .clr_zero(clr_zero)
  );

  AST_VMATCH_LINE_START: assert property (@(posedge clk) disable iff (rst)
    (flag_set && ($past(sel) == MATCH_V)) |-> (h_count == '0 && v_count == $past(v_cmp))); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (h_count == '0 && v_count == '0 && !flag_set && !clr_zero)); // R1
endmodule

// File: tb/tb_hv_match_timer.sv
module tb_hv_match_timer;
  localparam int H_W = 7, V_W = 4, CMP_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, lin_mode = 1'b0, region_sel = 1'b0, irq_en = 1'b0;
  logic [1:0] match_sel = 2'd0;
  logic [CMP_W-1:0] h_cmp = '0;
  logic [V_W-1:0] v_cmp = '0;
  logic [H_W-1:0] h_count;
  logic [V_W-1:0] v_count;
  logic flag_set, clr_zero;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hv_match_timer #(
    .H_W(H_W), .V_W(V_W), .CMP_W(CMP_W), .STEP(2), .DOT_SHIFT(2),
    .LINE_CLKS(40), .LINES_A(5), .LINES_B(7)
  ) dut (
    .clk(clk), .rst(rst), .tick(tick), .lin_mode(lin_mode),
    .region_sel(region_sel), .match_sel(match_sel), .h_cmp(h_cmp),
    .v_cmp(v_cmp), .irq_en(irq_en), .h_count(h_count), .v_count(v_count),
    .flag_set(flag_set), .clr_zero(clr_zero)
  );

  // columns: ticks to apply, lin_mode, expected h, expected v, requirement
  localparam int TBL[8][5] = '{
    '{1,  0, 2,  0, 2},
    '{18, 0, 38, 0, 2},
    '{1,  0, 0,  1, 3},
    '{60, 0, 0,  4, 3},
    '{20, 0, 0,  0, 4},
    '{10, 1, 20, 0, 5},
    '{54, 1, 0,  1, 5},
    '{1,  0, 2,  1, 11}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; lin_mode = 1'b0; region_sel = 1'b0;
    match_sel = 2'd0; irq_en = 1'b0; h_cmp = '0; v_cmp = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // each tick: strobe high for one cycle, sample the registered events after it
  task automatic run_ticks(input int n, output int pulses, output int clrs,
                           output int first);
    pulses = 0; clrs = 0; first = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (flag_set) begin
        pulses++;
        if (first < 0) first = i;
      end
      if (clr_zero) clrs++;
    end
  endtask

  task automatic watch_idle(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (flag_set) pulses++;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int p, c, f;
    // R1 reset state
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    chk("R1 h during reset", h_count, 0);
    chk("R1 v during reset", v_count, 0);
    chk("R1 flag during reset", flag_set, 0);
    do_reset();
    chk("R1 h after reset", h_count, 0);
    chk("R1 v after reset", v_count, 0);
    chk("R1 clr after reset", clr_zero, 0);

    // table walk, cumulative from reset
    for (int e = 0; e < 8; e++) begin
      lin_mode = TBL[e][1][0];
      run_ticks(TBL[e][0], p, c, f);
      chk($sformatf("R%0d table h entry %0d", TBL[e][4], e), h_count, TBL[e][2]);
      chk($sformatf("R%0d table v entry %0d", TBL[e][4], e), v_count, TBL[e][3]);
    end

    // R2 idle cycles hold counts
    watch_idle(5, p);
    chk("R2 hold h", h_count, 2);
    chk("R2 hold v", v_count, 1);

    // R4 second region total
    do_reset(); region_sel = 1'b1;
    run_ticks(100, p, c, f);
    chk("R4 region1 v before wrap", v_count, 5);
    run_ticks(40, p, c, f);
    chk("R4 region1 v wrap", v_count, 0);
    chk("R4 region1 h wrap", h_count, 0);

    // R5 full linear wrap
    do_reset(); lin_mode = 1'b1;
    run_ticks(1023, p, c, f);
    chk("R5 linear h top", h_count, 126);
    chk("R5 linear v top", v_count, 15);
    run_ticks(1, p, c, f);
    chk("R5 linear h wrap", h_count, 0);
    chk("R5 linear v wrap", v_count, 0);

    // R11 mode switch keeps counts, out-of-range v folds at next line step
    do_reset(); lin_mode = 1'b1;
    run_ticks(640, p, c, f);
    @(negedge clk); lin_mode = 1'b0;
    watch_idle(2, p);
    chk("R11 h kept on switch", h_count, 0);
    chk("R11 v kept on switch", v_count, 10);
    run_ticks(19, p, c, f);
    chk("R11 raster h after switch", h_count, 38);
    run_ticks(1, p, c, f);
    chk("R11 v folds to zero", v_count, 0);

    // R6 + R10 horizontal match, irq enabled: target 5*4=20 clocks = tick 10
    do_reset(); match_sel = 2'd1; h_cmp = 5'd5; irq_en = 1'b1;
    run_ticks(20, p, c, f);
    chk("R6 h match pulses", p, 1);
    chk("R6 h match tick", f, 10);
    chk("R10 clr with irq", c, 1);
    // R6 high target 31*4=124 in linear mode -> tick 62
    do_reset(); lin_mode = 1'b1; match_sel = 2'd1; h_cmp = 5'd31;
    run_ticks(64, p, c, f);
    chk("R6 top target tick", f, 62);
    chk("R10 no clr without irq", c, 0);

    // R7 vertical match at line start: v=2,h=0 after tick 40
    do_reset(); match_sel = 2'd2; v_cmp = 4'd2; irq_en = 1'b1;
    run_ticks(100, p, c, f);
    chk("R7 v match pulses", p, 1);
    chk("R7 v match tick", f, 40);

    // R8 both: v=1, h=12 -> tick 26
    do_reset(); match_sel = 2'd3; v_cmp = 4'd1; h_cmp = 5'd3;
    run_ticks(100, p, c, f);
    chk("R8 hv match pulses", p, 1);
    chk("R8 hv match tick", f, 26);

    // R9 off: conditions present but no flag
    do_reset(); match_sel = 2'd0; v_cmp = 4'd1; h_cmp = 5'd3; irq_en = 1'b1;
    run_ticks(100, p, c, f);
    chk("R9 off pulses", p, 0);
    chk("R9 off clr", c, 0);

    // R12 match tested on post-tick counts only; h_cmp=0 first hit at tick 20
    do_reset(); match_sel = 2'd1; h_cmp = 5'd0;
    watch_idle(4, p);
    chk("R12 no pulse at reset zero", p, 0);
    run_ticks(20, p, c, f);
    chk("R12 first hit after wrap", f, 20);
    chk("R12 single pulse", p, 1);
    watch_idle(6, p);
    chk("R12 idle on match point", p, 0);

    summary();
  end
endmodule